// File: doc/BRIEF.md
# Microcode-Driven Control Sequencer

This block is a control unit whose behaviour lives in a small microcode store rather than in hand-written next-state equations. A microprogram address register selects one stored word per cycle. The word supplies a control vector, which is driven straight out to a datapath. It also supplies a sequencing instruction, which decides the address used on the following clock edge.

Four sequencing kinds are supported: step to the following word, jump to a named word, stay on the current word, and a two-way conditional branch. A conditional word names one status flag and an even base address. The value of the chosen flag becomes the low bit of the next address, so every decision lands on one of two neighbouring words. The microprogram is a constant table computed in the code; changing behaviour means changing that table, not the sequencing hardware.

Top module: `mseq_ctrl`

## Requirements
- R1: While reset is low, and for the two clock edges after its release (reset synchroniser latency), the address output is 0 and the control output is the control field of word 0 (0x01).
- R2: A word whose sequencing code is 0 (step) makes the next address equal to the current address plus one, modulo the store depth.
- R3: A word whose sequencing code is 1 (jump) makes the next address equal to its target field.
- R4: A word whose sequencing code is 2 (branch) whose selected flag is 0 makes the next address equal to its target field (the base).
- R5: A branch word whose selected flag is 1 makes the next address the base plus one; every base used by a branch word is even.
- R6: A word whose sequencing code is 3 (hold) keeps the address unchanged until reset.
- R7: The control output always equals the control field of the word at the current address output, in the same cycle.
- R8: A branch depends only on the flag whose index its select field holds; flags sampled are those present in the cycle the branch word is current, and the other flag bits have no effect on the next address.
- R9: The stored program (address: kind, argument, control value) is 0: step, 0x01; 1: branch on flag 0 base 4, 0x02; 4: jump 6, 0x04; 5: step, 0x05; 6: branch on flag 1 base 8, 0x06; 8: jump 10, 0x08; 9: jump 10, 0x09; 10: branch on flag 2 base 12, 0x0A; 12: jump 14, 0x0C; 13: branch on flag 3 base 14, 0x0D; 14: jump 0, 0x0E; 15: hold, 0x0F; every other address: jump 0, control 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised internally |
| flags_i | input | NUM_FLAGS | Status flags from the datapath |
| ctrl_o | output | CTRL_W | Control field of the current microinstruction |
| upc_o | output | ADDR_W | Current microprogram address |

## Verification
The bench builds the block with its defaults: a 4-bit address (16 words), four flags and an 8-bit control vector. This is the smallest shape in which the stored program uses all four sequencing kinds and a branch on every flag index. Holding each of the sixteen flag patterns for a full pass sends every branch both ways and reaches the hold word. A random-flag phase then shows that unselected flags never steer a branch.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {
    OP_STEP   = 2'd0,
    OP_JUMP   = 2'd1,
    OP_BRANCH = 2'd2,
    OP_HOLD   = 2'd3
  } seq_op_e;

endpackage

// File: rtl/mseq_rst_sync.sv
module mseq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FSEL_W = 2,
  parameter int CTRL_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output seq_op_e           op_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [CTRL_W-1:0] ctrl_o
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 + FSEL_W + ADDR_W + CTRL_W;

  function automatic logic [WORD_W-1:0] mk(seq_op_e op, int f, int t, int c);
    return {op, FSEL_W'(f), ADDR_W'(t), CTRL_W'(c)};
  endfunction

  function automatic logic [WORD_W-1:0] entry(int i);
    case (i)
      0:       return mk(OP_STEP,   0,  0, 'h01);
      1:       return mk(OP_BRANCH, 0,  4, 'h02);
      4:       return mk(OP_JUMP,   0,  6, 'h04);
      5:       return mk(OP_STEP,   0,  0, 'h05);
      6:       return mk(OP_BRANCH, 1,  8, 'h06);
      8:       return mk(OP_JUMP,   0, 10, 'h08);
      9:       return mk(OP_JUMP,   0, 10, 'h09);
      10:      return mk(OP_BRANCH, 2, 12, 'h0A);
      12:      return mk(OP_JUMP,   0, 14, 'h0C);
      13:      return mk(OP_BRANCH, 3, 14, 'h0D);
      14:      return mk(OP_JUMP,   0,  0, 'h0E);
      15:      return mk(OP_HOLD,   0,  0, 'h0F);
      default: return mk(OP_JUMP,   0,  0, 'h00);
    endcase
  endfunction

  logic [WORD_W-1:0] store_w [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign store_w[gi] = entry(gi);
  end

  logic [WORD_W-1:0] word_w;
  assign word_w = store_w[addr_i];

  assign op_o   = seq_op_e'(word_w[WORD_W-1 -: 2]);
  assign fsel_o = word_w[CTRL_W+ADDR_W +: FSEL_W];
  assign tgt_o  = word_w[CTRL_W +: ADDR_W];
  assign ctrl_o = word_w[CTRL_W-1:0];

endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_FLAGS = 4,
  parameter int FSEL_W    = 2
) (
  input  logic [ADDR_W-1:0]    upc_i,
  input  seq_op_e              op_i,
  input  logic [FSEL_W-1:0]    fsel_i,
  input  logic [ADDR_W-1:0]    tgt_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [ADDR_W-1:0]    upc_d_o
);

  logic cond_bit;

  always_comb begin
    if (int'(fsel_i) < NUM_FLAGS) cond_bit = flags_i[fsel_i];
    else                          cond_bit = 1'b0;
  end

  always_comb begin
    unique case (op_i)
      OP_STEP:   upc_d_o = upc_i + ADDR_W'(1);
      OP_JUMP:   upc_d_o = tgt_i;
      OP_BRANCH: upc_d_o = {tgt_i[ADDR_W-1:1], cond_bit};
      OP_HOLD:   upc_d_o = upc_i;
      default:   upc_d_o = upc_i;
    endcase
  end

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_FLAGS = 4,
  parameter int CTRL_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [CTRL_W-1:0]    ctrl_o,
  output logic [ADDR_W-1:0]    upc_o
);

  localparam int FSEL_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] upc_q, upc_d;
  seq_op_e           op;
  logic [FSEL_W-1:0] fsel;
  logic [ADDR_W-1:0] tgt;

  mseq_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  mseq_rom #(.ADDR_W(ADDR_W), .FSEL_W(FSEL_W), .CTRL_W(CTRL_W)) u_rom (
    .addr_i (upc_q),
    .op_o   (op),
    .fsel_o (fsel),
    .tgt_o  (tgt),
    .ctrl_o (ctrl_o)
  );

  mseq_next #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS), .FSEL_W(FSEL_W)) u_next (
    .upc_i   (upc_q),
    .op_i    (op),
    .fsel_i  (fsel),
    .tgt_i   (tgt),
    .flags_i (flags_i),
    .upc_d_o (upc_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) upc_q <= '0;
    else             upc_q <= upc_d;
  end

  assign upc_o = upc_q;

  a_r2_step_increments: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    op == OP_STEP |=> upc_q == $past(upc_q) + ADDR_W'(1));

  a_r3_jump_lands_on_target: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    op == OP_JUMP |=> upc_q == $past(tgt));

  a_r5_branch_base_even: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    op == OP_BRANCH |-> tgt[0] == 1'b0);

  a_r8_branch_follows_flag: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    op == OP_BRANCH |=> upc_q[ADDR_W-1:1] == $past(tgt[ADDR_W-1:1]) &&
                        upc_q[0] == $past(flags_i[fsel]));

  a_r6_hold_keeps_address: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    op == OP_HOLD |=> $stable(upc_q));

endmodule

// File: tb/mseq_ctrl_tb.sv
`timescale 1ns/1ps
module mseq_ctrl_tb;

  localparam int ADDR_W = 4;
  localparam int NFL    = 4;
  localparam int CW     = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NFL-1:0]  flags = '0;
  logic [CW-1:0]   ctrl;
  logic [ADDR_W-1:0] upc;

  int vectors = 0;
  int misses  = 0;
  int m_pc    = 0;
  int hold    = 2;
  string tag  = "R1";
  bit random_phase = 0;

  always #5 clk = ~clk;

  mseq_ctrl #(.ADDR_W(ADDR_W), .NUM_FLAGS(NFL), .CTRL_W(CW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .flags_i (flags), .ctrl_o (ctrl), .upc_o (upc)
  );

  // R9 program as specified: kind 0 step,1 jump,2 branch,3 hold
  task automatic spec(input int a, output int kind, output int f, output int t, output int c);
    f = 0; t = 0;
    case (a)
      0:  begin kind = 0; c = 'h01; end
      1:  begin kind = 2; f = 0; t = 4;  c = 'h02; end
      4:  begin kind = 1; t = 6;  c = 'h04; end
      5:  begin kind = 0; c = 'h05; end
      6:  begin kind = 2; f = 1; t = 8;  c = 'h06; end
      8:  begin kind = 1; t = 10; c = 'h08; end
      9:  begin kind = 1; t = 10; c = 'h09; end
      10: begin kind = 2; f = 2; t = 12; c = 'h0A; end
      12: begin kind = 1; t = 14; c = 'h0C; end
      13: begin kind = 2; f = 3; t = 14; c = 'h0D; end
      14: begin kind = 1; t = 0;  c = 'h0E; end
      15: begin kind = 3; c = 'h0F; end
      default: begin kind = 1; t = 0; c = 'h00; end
    endcase
  endtask

  task automatic step(input logic [NFL-1:0] fv, input logic rv);
    int kind, f, t, c;
    @(negedge clk);
    spec(m_pc, kind, f, t, c);
    vectors++;
    if (int'(upc) != m_pc) begin
      misses++;
      $display("FAIL %s address: actual %0d expected %0d", tag, upc, m_pc);
    end
    vectors++;
    if (int'(ctrl) != c) begin
      misses++;
      $display("FAIL R7 control at %0d: actual 0x%0h expected 0x%0h", m_pc, ctrl, c);
    end
    flags = fv;
    rst_n = rv;
    if (!rv) begin
      m_pc = 0; hold = 2; tag = "R1";
    end else if (hold > 0) begin
      hold--; tag = "R1";
    end else begin
      case (kind)
        0: begin m_pc = (m_pc + 1) % DEPTH; tag = "R2"; end
        1: begin m_pc = t; tag = "R3"; end
        2: begin
             m_pc = t + int'(fv[f]);
             if (random_phase) tag = "R8";
             else tag = fv[f] ? "R5" : "R4";
           end
        default: tag = "R6";
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: reset state, then each flag pattern held for a whole pass (R2..R6)
    for (int p = 0; p < 16; p++) begin
      step(4'(p), 1'b0);
      step(4'(p), 1'b0);
      for (int k = 0; k < 14; k++) step(4'(p), 1'b1);
    end
    // R8: flags change every cycle; only the selected one may matter
    random_phase = 1;
    for (int k = 0; k < 300; k++) begin
      step(4'($urandom), (k % 40) != 39);
    end
    step('0, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule